// File: doc/BRIEF.md
# Bit Manipulation Execution Unit

This block is a purely combinational execution unit for register-level bit work. It takes a 4-bit opcode, a primary source word, a secondary source that is either a second register word or an immediate mask, and two bit-index fields. From these it forms one result word and a single-bit test flag. A branch unit elsewhere can use that flag to decide whether a bit-test branch is taken.

It covers three groups of operation. The bitwise group is AND, OR, XOR, AND-with-complement and OR-with-complement. The direct-bit group sets an inclusive bit range, clears an inclusive bit range, or tests one bit. The shift group is shift left with zero fill, shift left with one fill, and rotate left.

The range operations modify the primary source word, which carries the old destination value. Every result appears in the same cycle as its inputs. The data width is a parameter and defaults to 8 bits. The index fields have one bit more than a bit index needs, so amounts equal to or beyond the width can be expressed.

Top module: `bmu_top`

## Requirements
- R1: Opcodes 0 (AND), 1 (OR) and 2 (XOR) combine `src_a_i` bitwise with the second operand. The second operand is `imm_i` when `use_imm_i` is 1 and `src_b_i` otherwise. With 8-bit data, AND with immediate 128 keeps only bit 7, and OR with immediate 128 forces bit 7 to 1.
- R2: Opcode 3 gives `src_a_i & ~operand` and opcode 4 gives `src_a_i | ~operand`, using the same operand choice as in R1.
- R3: Opcode 5 returns `src_a_i` with every bit from index min(n,m) through max(n,m) inclusive forced to 1. Indices above WIDTH-1 are clamped to WIDTH-1, and all other bits are unchanged.
- R4: Opcode 6 returns `src_a_i` with the same inclusive, order-independent, clamped range forced to 0. All other bits are unchanged.
- R5: Opcode 7 drives `bit_set_o` to bit n of `src_a_i`, or to 0 when n >= WIDTH, and returns a result of 0. For every other opcode `bit_set_o` is 0.
- R6: Opcode 8 shifts `src_a_i` left by n and fills the vacated low bits with 0. When n >= WIDTH the result is all zeros.
- R7: Opcode 9 shifts `src_a_i` left by n and fills the vacated low bits with 1. When n >= WIDTH the result is all ones.
- R8: Opcode 10 rotates `src_a_i` left by n modulo WIDTH, so bits leaving the top re-enter at the bottom.
- R9: Opcodes 11 through 15 return a result of 0 and set `illegal_o` to 1. `illegal_o` is 0 for opcodes 0 through 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code (0..10 defined) |
| src_a_i | input | WIDTH | Primary source / old destination word |
| src_b_i | input | WIDTH | Second register operand |
| imm_i | input | WIDTH | Immediate mask operand |
| use_imm_i | input | 1 | 1 selects `imm_i` as second operand |
| idx_n_i | input | IDX_W | Bit index n, or shift/rotate amount |
| idx_m_i | input | IDX_W | Second bit index m for range operations |
| result_o | output | WIDTH | Result word |
| bit_set_o | output | 1 | Bit-test flag for branching |
| illegal_o | output | 1 | Undefined opcode indicator |

## Verification
The unit has no registers, so the result word, the test flag and the illegal indication are all due in the same cycle their inputs are applied. The bench drives each vector just after a rising clock edge and compares all three outputs at the following falling edge. The comparison is against a behavioural model computed bit by bit. Each vector is therefore checked in the half cycle it was presented, and no later vector can mask a wrong value.

// File: rtl/bmu_pkg.sv
package bmu_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_AND  = 4'd0,
        OP_OR   = 4'd1,
        OP_XOR  = 4'd2,
        OP_ANDN = 4'd3,
        OP_ORN  = 4'd4,
        OP_BSET = 4'd5,
        OP_BCLR = 4'd6,
        OP_BTST = 4'd7,
        OP_SLZ  = 4'd8,
        OP_SLO  = 4'd9,
        OP_ROTL = 4'd10
    } bmu_op_e;

endpackage

// File: rtl/bmu_logic.sv
module bmu_logic
    import bmu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [OP_W-1:0]  op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] res_o
);

    always_comb begin
        res_o = '0;
        case (op_i)
            OP_AND:  res_o = a_i & b_i;
            OP_OR:   res_o = a_i | b_i;
            OP_XOR:  res_o = a_i ^ b_i;
            OP_ANDN: res_o = a_i & ~b_i;
            OP_ORN:  res_o = a_i | ~b_i;
            default: res_o = '0;
        endcase
    end

endmodule

// File: rtl/bmu_range.sv
module bmu_range #(
    parameter int WIDTH = 8,
    parameter int IDX_W = 4
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [IDX_W-1:0] n_i,
    input  logic [IDX_W-1:0] m_i,
    output logic [WIDTH-1:0] set_o,
    output logic [WIDTH-1:0] clr_o,
    output logic             test_o
);

    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(WIDTH - 1);

    logic [IDX_W-1:0] n_cl, m_cl, lo, hi;
    logic [WIDTH-1:0] mask;
    logic [WIDTH-1:0] sel;

    always_comb begin
        n_cl = (n_i > TOP_IDX) ? TOP_IDX : n_i;
        m_cl = (m_i > TOP_IDX) ? TOP_IDX : m_i;
        if (n_cl > m_cl) begin
            lo = m_cl;
            hi = n_cl;
        end else begin
            lo = n_cl;
            hi = m_cl;
        end
    end

    for (genvar g = 0; g < WIDTH; g++) begin : g_mask
        assign mask[g] = (IDX_W'(g) >= lo) && (IDX_W'(g) <= hi);
    end

    assign set_o  = a_i | mask;
    assign clr_o  = a_i & ~mask;
    assign sel    = a_i >> n_i;
    assign test_o = sel[0];

endmodule

// File: rtl/bmu_shift.sv
module bmu_shift #(
    parameter int WIDTH = 8,
    parameter int IDX_W = 4
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [IDX_W-1:0] n_i,
    output logic [WIDTH-1:0] slz_o,
    output logic [WIDTH-1:0] slo_o,
    output logic [WIDTH-1:0] rot_o
);

    localparam logic [IDX_W-1:0] W_IDX = IDX_W'(WIDTH);

    logic             sat;
    logic [IDX_W-1:0] rot_amt;
    logic [2*WIDTH-1:0] dbl;

    assign sat     = (n_i >= W_IDX);
    assign slz_o   = sat ? '0 : (a_i << n_i);
    assign slo_o   = sat ? '1 : ~((~a_i) << n_i);
    assign rot_amt = IDX_W'(n_i % W_IDX);
    assign dbl     = {a_i, a_i} << rot_amt;
    assign rot_o   = dbl[2*WIDTH-1:WIDTH];

endmodule

// File: rtl/bmu_top.sv
module bmu_top
    import bmu_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int IDX_W = $clog2(WIDTH) + 1
) (
    input  logic [3:0]       op_i,
    input  logic [WIDTH-1:0] src_a_i,
    input  logic [WIDTH-1:0] src_b_i,
    input  logic [WIDTH-1:0] imm_i,
    input  logic             use_imm_i,
    input  logic [IDX_W-1:0] idx_n_i,
    input  logic [IDX_W-1:0] idx_m_i,
    output logic [WIDTH-1:0] result_o,
    output logic             bit_set_o,
    output logic             illegal_o
);

    logic [WIDTH-1:0] opnd_b;
    logic [WIDTH-1:0] logic_res, set_res, clr_res, slz_res, slo_res, rot_res;
    logic             test_bit;

    assign opnd_b = use_imm_i ? imm_i : src_b_i;

    bmu_logic #(.WIDTH(WIDTH)) u_logic (
        .op_i  (op_i),
        .a_i   (src_a_i),
        .b_i   (opnd_b),
        .res_o (logic_res)
    );

    bmu_range #(.WIDTH(WIDTH), .IDX_W(IDX_W)) u_range (
        .a_i    (src_a_i),
        .n_i    (idx_n_i),
        .m_i    (idx_m_i),
        .set_o  (set_res),
        .clr_o  (clr_res),
        .test_o (test_bit)
    );

    bmu_shift #(.WIDTH(WIDTH), .IDX_W(IDX_W)) u_shift (
        .a_i   (src_a_i),
        .n_i   (idx_n_i),
        .slz_o (slz_res),
        .slo_o (slo_res),
        .rot_o (rot_res)
    );

    always_comb begin
        result_o  = '0;
        bit_set_o = 1'b0;
        illegal_o = 1'b0;
        case (op_i)
            OP_AND, OP_OR, OP_XOR, OP_ANDN, OP_ORN: result_o = logic_res;
            OP_BSET: result_o  = set_res;
            OP_BCLR: result_o  = clr_res;
            OP_BTST: bit_set_o = test_bit;
            OP_SLZ:  result_o  = slz_res;
            OP_SLO:  result_o  = slo_res;
            OP_ROTL: result_o  = rot_res;
            default: illegal_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/bmu_chk.sv
module bmu_chk
    import bmu_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int IDX_W = 4
) (
    input logic [3:0]       op_i,
    input logic [WIDTH-1:0] src_a_i,
    input logic [WIDTH-1:0] src_b_i,
    input logic [WIDTH-1:0] imm_i,
    input logic             use_imm_i,
    input logic [IDX_W-1:0] idx_n_i,
    input logic [IDX_W-1:0] idx_m_i,
    input logic [WIDTH-1:0] result_o,
    input logic             bit_set_o,
    input logic             illegal_o
);

    localparam logic [IDX_W-1:0] W_IDX = IDX_W'(WIDTH);

    always_comb begin
        if (!$isunknown({op_i, src_a_i, src_b_i, imm_i, use_imm_i, idx_n_i, idx_m_i,
                         result_o, bit_set_o, illegal_o})) begin
            assert_illegal_zero_R9: assert (!illegal_o || (result_o == '0 && !bit_set_o))
                else $error("illegal opcode produced data");
            assert_flag_only_test_R5: assert (!bit_set_o || op_i == OP_BTST)
                else $error("bit flag raised outside bit test");
            assert_set_keeps_ones_R3: assert (op_i != OP_BSET || (result_o & src_a_i) == src_a_i)
                else $error("range set cleared a bit");
            assert_clr_keeps_zeros_R4: assert (op_i != OP_BCLR || (result_o & ~src_a_i) == '0)
                else $error("range clear set a bit");
            assert_one_fill_sat_R7: assert (op_i != OP_SLO || idx_n_i < W_IDX || result_o == '1)
                else $error("saturated one-fill shift not all ones");
            assert_rot_popcount_R8: assert (op_i != OP_ROTL || $countones(result_o) == $countones(src_a_i))
                else $error("rotate changed number of ones");
        end
    end

endmodule

bind bmu_top bmu_chk #(.WIDTH(WIDTH), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/test_bmu_top.sv
`timescale 1ns/1ps
module test_bmu_top;

    localparam int W  = 8;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    op;
    logic [W-1:0]  a, b, imm;
    logic          ui;
    logic [IW-1:0] n, m;
    logic [W-1:0]  res;
    logic          flag, ill;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    bmu_top #(.WIDTH(W), .IDX_W(IW)) i_bmu_top (
        .op_i(op), .src_a_i(a), .src_b_i(b), .imm_i(imm), .use_imm_i(ui),
        .idx_n_i(n), .idx_m_i(m),
        .result_o(res), .bit_set_o(flag), .illegal_o(ill)
    );

    function automatic string req_of(input int o);
        case (o)
            0, 1, 2: return "R1";
            3, 4:    return "R2";
            5:       return "R3";
            6:       return "R4";
            7:       return "R5";
            8:       return "R6";
            9:       return "R7";
            10:      return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic model(input int o, input logic [W-1:0] xa, xb, xi, input logic xu,
                         input int xn, xm,
                         output logic [W-1:0] r, output logic f, output logic il);
        logic [W-1:0] ob;
        int lo, hi, k;
        ob = xu ? xi : xb;
        r = '0; f = 1'b0; il = 1'b0;
        case (o)
            0: r = xa & ob;
            1: r = xa | ob;
            2: r = xa ^ ob;
            3: r = xa & ~ob;
            4: r = xa | ~ob;
            5, 6: begin
                lo = (xn < xm) ? xn : xm;
                hi = (xn < xm) ? xm : xn;
                if (lo > W-1) lo = W-1;
                if (hi > W-1) hi = W-1;
                r = xa;
                for (int i = lo; i <= hi; i++) r[i] = (o == 5);
            end
            7: f = (xn < W) ? xa[xn] : 1'b0;
            8, 9: for (int i = 0; i < W; i++) r[i] = (i >= xn) ? xa[i-xn] : (o == 9);
            10: begin
                k = xn % W;
                for (int i = 0; i < W; i++) r[i] = xa[(i - k + W) % W];
            end
            default: il = 1'b1;
        endcase
    endtask

    task automatic apply(input int o, input logic [W-1:0] xa, xb, xi, input logic xu,
                         input int xn, xm);
        logic [W-1:0] er;
        logic ef, eil;
        @(posedge clk);
        op = 4'(o); a = xa; b = xb; imm = xi; ui = xu; n = IW'(xn); m = IW'(xm);
        model(o, xa, xb, xi, xu, xn, xm, er, ef, eil);
        @(negedge clk);
        checks++;
        if (res !== er || flag !== ef || ill !== eil) begin
            errors++;
            $display("FAIL %s op=%0d a=%h n=%0d m=%0d: got res=%h flag=%b ill=%b expected res=%h flag=%b ill=%b",
                     req_of(o), o, xa, xn, xm, res, flag, ill, er, ef, eil);
        end
    endtask

    initial begin
        op = '0; a = '0; b = '0; imm = '0; ui = 1'b0; n = '0; m = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // reset-state / idle check: AND of zeros
        apply(0, 8'h00, 8'h00, 8'h00, 0, 0, 0);
        // R1: immediate mask 128 keeps / sets top bit
        apply(0, 8'hFF, 8'h00, 8'd128, 1, 0, 0);
        apply(1, 8'h15, 8'h00, 8'd128, 1, 0, 0);
        apply(2, 8'hA5, 8'h3C, 8'hFF, 0, 0, 0);
        // R2
        apply(3, 8'hF0, 8'h3C, 8'h00, 0, 0, 0);
        apply(4, 8'h01, 8'h00, 8'h0F, 1, 0, 0);
        // R3 / R4: ordered, equal, swapped, clamped
        apply(5, 8'h00, 0, 0, 0, 2, 5);
        apply(5, 8'h81, 0, 0, 0, 6, 1);
        apply(5, 8'h00, 0, 0, 0, 4, 4);
        apply(5, 8'h00, 0, 0, 0, 5, 15);
        apply(6, 8'hFF, 0, 0, 0, 2, 5);
        apply(6, 8'hFF, 0, 0, 0, 7, 0);
        apply(6, 8'hFF, 0, 0, 0, 12, 6);
        // R5
        apply(7, 8'h08, 0, 0, 0, 3, 0);
        apply(7, 8'hF7, 0, 0, 0, 3, 0);
        apply(7, 8'hFF, 0, 0, 0, 9, 0);
        // R6 / R7
        apply(8, 8'hB7, 0, 0, 0, 0, 0);
        apply(8, 8'hB7, 0, 0, 0, 3, 0);
        apply(8, 8'hB7, 0, 0, 0, 8, 0);
        apply(9, 8'h00, 0, 0, 0, 3, 0);
        apply(9, 8'h12, 0, 0, 0, 12, 0);
        // R8
        apply(10, 8'h81, 0, 0, 0, 3, 0);
        apply(10, 8'h81, 0, 0, 0, 11, 0);
        apply(10, 8'h5A, 0, 0, 0, 8, 0);
        // R9
        apply(11, 8'hFF, 8'hFF, 8'hFF, 1, 3, 5);
        apply(15, 8'hFF, 8'hFF, 8'hFF, 0, 7, 7);
        // mixed pseudo-random vectors over all opcodes
        for (int t = 0; t < 600; t++) begin
            apply(int'($urandom_range(0, 15)), W'($urandom), W'($urandom), W'($urandom),
                  1'($urandom), int'($urandom_range(0, 15)), int'($urandom_range(0, 15)));
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4.0 * 200000);
        if (!done) begin
            errors++;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule